// File: doc/BRIEF.md
# Transmit Queue Ready Arbiter

This block decides when a transmit queue holds enough data for the MAC transmitter to start on it. It keeps two occupancy counts: the number of memory blocks stored in the queue, and the number of stored blocks that close a frame. A two-bit rule field selects which condition raises the ready flag. The rules are: any data present, a block level above a programmable threshold, at least one whole frame stored, or a whole frame OR the level condition.

The same threshold drives a low-water interrupt to the host. The flag sets when the stored block count drops from at or above the threshold to below it. The host clears it by writing 1. A fast host can use it to stream a frame larger than the queue. It preloads blocks, takes the interrupt, tops the queue back up above the threshold, and repeats until the frame's last block is written.

The frame memory, the transmitter and the host bus are outside this block. It only sees push and pop events, each with an end-of-frame qualifier.

Top module: `txq_ready_arbiter`

## Requirements
- R1: Reset clears the block count, the frame count, `q_ready`, `lw_irq` and `push_overflow`.
- R2: An accepted push adds one block and an accepted pop removes one. When a push and a pop arrive together the count is unchanged, including when the queue is full.
- R3: A push while the count equals `DEPTH` is rejected when no pop accompanies it. `push_overflow` is then high for the single cycle after that clock edge.
- R4: A pop while the queue is empty is ignored. The count stays at zero and no output changes.
- R5: With `rdy_rule` = 2'b00, `q_ready` is high whenever at least one block is stored.
- R6: With `rdy_rule` = 2'b01, `q_ready` is high exactly when the block count is greater than `lw_thresh`.
- R7: With `rdy_rule` = 2'b10, `q_ready` is high only while at least one end-of-frame block is stored. A frame longer than `DEPTH` blocks never raises it: the queue fills, further pushes overflow, and ready stays low.
- R8: With `rdy_rule` = 2'b11, `q_ready` is high when an end-of-frame block is stored OR the block count is greater than `lw_thresh`.
- R9: The frame count rises on an accepted push with `eop_push` high. It falls on an accepted pop with `eop_pop` high while it is non-zero.
- R10: `lw_irq` sets on the clock edge where the block count moves from at least `lw_thresh` to below it.
- R11: `lw_irq` stays set until a cycle with `lw_irq_clr` high. A new crossing in the clearing cycle wins and keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_push | input | 1 | One block written into the queue |
| eop_push | input | 1 | The pushed block ends a frame |
| blk_pop | input | 1 | One block drained by the transmitter |
| eop_pop | input | 1 | The drained block ends a frame |
| rdy_rule | input | 2 | Ready rule: 00 any data, 01 level, 10 whole frame, 11 frame or level |
| lw_thresh | input | CW | Block-count threshold for the level rule and the interrupt |
| lw_irq_clr | input | 1 | Write-1 clear of the low-water interrupt |
| q_ready | output | 1 | Queue may start transmitting |
| lw_irq | output | 1 | Sticky low-water interrupt |
| push_overflow | output | 1 | A push was rejected at the previous edge |

## Verification
The bench fills the queue past capacity in whole-frame mode. A design that let an oversized frame through would raise ready there, and one that did not saturate would wrap the count and never overflow. It pushes and pops in the same cycle at full, which catches a design that rejects the push or moves the count. It drains across the threshold one block at a time, so an interrupt one block early or late, or one raised on levels rather than on the crossing, shows up. Clears coinciding with idle cycles and with fresh crossings catch a wrong priority between set and clear.

// File: rtl/txq_arb_pkg.sv
package txq_arb_pkg;
    typedef enum logic [1:0] {
        RULE_ANY_DATA    = 2'b00,
        RULE_LEVEL       = 2'b01,
        RULE_FRAME       = 2'b10,
        RULE_FRAME_LEVEL = 2'b11
    } rdy_rule_e;
endpackage

// File: rtl/txq_occupancy.sv
module txq_occupancy #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_push,
    input  logic          eop_push,
    input  logic          blk_pop,
    input  logic          eop_pop,
    output logic [CW-1:0] blk_cnt,
    output logic [CW-1:0] blk_cnt_nxt,
    output logic [CW-1:0] eop_cnt,
    output logic          overflow
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] blk;
        logic [CW-1:0] eop;
        logic          ovf;
    } occ_t;

    occ_t st_d, st_q;
    logic pop_ok, push_ok, eop_inc, eop_dec;

    always_comb begin
        st_d    = st_q;
        pop_ok  = blk_pop && (st_q.blk != '0);
        push_ok = blk_push && ((st_q.blk != FULL) || pop_ok);
        eop_inc = push_ok && eop_push;
        eop_dec = pop_ok && eop_pop && (st_q.eop != '0);
        case ({push_ok, pop_ok})
            2'b10:   st_d.blk = st_q.blk + 1'b1;
            2'b01:   st_d.blk = st_q.blk - 1'b1;
            default: st_d.blk = st_q.blk;
        endcase
        case ({eop_inc, eop_dec})
            2'b10:   st_d.eop = st_q.eop + 1'b1;
            2'b01:   st_d.eop = st_q.eop - 1'b1;
            default: st_d.eop = st_q.eop;
        endcase
        st_d.ovf = blk_push && !push_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign blk_cnt     = st_q.blk;
    assign blk_cnt_nxt = st_d.blk;
    assign eop_cnt     = st_q.eop;
    assign overflow    = st_q.ovf;

    // R2: count stays within capacity
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.blk <= FULL);
    // R3: overflow only after a push at full with no pop
    a_r3_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovf) |-> $past(blk_push && !blk_pop && st_q.blk == FULL));
    // R4: empty pop without push leaves count at zero
    a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.blk == '0 && blk_pop && !blk_push) |=> st_q.blk == '0);
    // R9: stored frame ends never outnumber stored blocks
    a_r9_eop_le_blk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.eop <= st_q.blk);
endmodule

// File: rtl/txq_ready_rule.sv
module txq_ready_rule
    import txq_arb_pkg::*;
#(
    parameter int CW = 5
) (
    input  rdy_rule_e     rule,
    input  logic [CW-1:0] blk_cnt,
    input  logic [CW-1:0] eop_cnt,
    input  logic [CW-1:0] thresh,
    output logic          ready
);
    logic has_data, has_frame, above;

    always_comb begin
        has_data  = (blk_cnt != '0);
        has_frame = (eop_cnt != '0);
        above     = (blk_cnt > thresh);
        case (rule)
            RULE_ANY_DATA:    ready = has_data;
            RULE_LEVEL:       ready = above;
            RULE_FRAME:       ready = has_frame;
            RULE_FRAME_LEVEL: ready = has_frame || above;
            default:          ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/txq_lowwater.sv
module txq_lowwater #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] blk_cnt,
    input  logic [CW-1:0] blk_cnt_nxt,
    input  logic [CW-1:0] thresh,
    input  logic          clr,
    output logic          irq
);
    typedef struct packed {
        logic flag;
    } lw_t;

    lw_t  st_d, st_q;
    logic crossing;

    always_comb begin
        crossing   = (blk_cnt >= thresh) && (blk_cnt_nxt < thresh);
        st_d.flag  = crossing || (st_q.flag && !clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.flag;

    // R10: a rising interrupt follows a downward threshold crossing
    a_r10_rise_on_cross: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> ($past(blk_cnt) >= $past(thresh) && blk_cnt < $past(thresh)));
    // R11: without a clear the flag never drops
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.flag) && !$past(clr)) |-> st_q.flag);
endmodule

// File: rtl/txq_ready_arbiter.sv
module txq_ready_arbiter
    import txq_arb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_push,
    input  logic          eop_push,
    input  logic          blk_pop,
    input  logic          eop_pop,
    input  logic [1:0]    rdy_rule,
    input  logic [CW-1:0] lw_thresh,
    input  logic          lw_irq_clr,
    output logic          q_ready,
    output logic          lw_irq,
    output logic          push_overflow
);
    logic [CW-1:0] blk_cnt, blk_cnt_nxt, eop_cnt;
    rdy_rule_e     rule;

    assign rule = rdy_rule_e'(rdy_rule);

    txq_occupancy #(.DEPTH(DEPTH), .CW(CW)) occ_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_push   (blk_push),
        .eop_push   (eop_push),
        .blk_pop    (blk_pop),
        .eop_pop    (eop_pop),
        .blk_cnt    (blk_cnt),
        .blk_cnt_nxt(blk_cnt_nxt),
        .eop_cnt    (eop_cnt),
        .overflow   (push_overflow)
    );

    txq_ready_rule #(.CW(CW)) rule_i (
        .rule   (rule),
        .blk_cnt(blk_cnt),
        .eop_cnt(eop_cnt),
        .thresh (lw_thresh),
        .ready  (q_ready)
    );

    txq_lowwater #(.CW(CW)) lw_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_cnt    (blk_cnt),
        .blk_cnt_nxt(blk_cnt_nxt),
        .thresh     (lw_thresh),
        .clr        (lw_irq_clr),
        .irq        (lw_irq)
    );

    // R7: whole-frame rule never signals ready without a stored frame end
    a_r7_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rule == RULE_FRAME && q_ready) |-> eop_cnt != '0);
    // R5: any-data rule is ready whenever a block is stored
    a_r5_any_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rule == RULE_ANY_DATA && blk_cnt != '0) |-> q_ready);
endmodule

// File: tb/txq_ready_arbiter_tb_top.sv
`timescale 1ns/100ps
module txq_ready_arbiter_tb_top;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NV    = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blk_push = 0, eop_push = 0, blk_pop = 0, eop_pop = 0, lw_irq_clr = 0;
    logic [1:0]    rdy_rule = 2'b00;
    logic [CW-1:0] lw_thresh = '0;
    logic q_ready, lw_irq, push_overflow;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    txq_ready_arbiter #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .blk_push(blk_push), .eop_push(eop_push),
        .blk_pop(blk_pop), .eop_pop(eop_pop), .rdy_rule(rdy_rule),
        .lw_thresh(lw_thresh), .lw_irq_clr(lw_irq_clr),
        .q_ready(q_ready), .lw_irq(lw_irq), .push_overflow(push_overflow)
    );

    // {push, eop_push, pop, eop_pop, clr, rule[1:0], thresh[4:0], exp_ready, exp_irq, exp_ovf}
    localparam logic [14:0] VECS [0:NV-1] = '{
        15'b1_0_0_0_0_11_00010_0_0_0, // R8 cnt1
        15'b1_0_0_0_0_11_00010_0_0_0, // R8 cnt2 not above
        15'b1_0_0_0_0_11_00010_1_0_0, // R8 cnt3 above
        15'b0_0_1_0_0_11_00010_0_0_0, // R10 cnt2 no crossing
        15'b0_0_1_0_0_11_00010_0_1_0, // R10 cnt1 crossing
        15'b0_0_0_0_1_11_00010_0_0_0, // R11 clear
        15'b1_1_0_0_0_11_00010_1_0_0, // R9 frame end stored
        15'b0_0_0_0_0_10_00010_1_0_0, // R7 frame present
        15'b0_0_1_0_0_10_00010_1_1_0, // R7 frame kept, R10 crossing
        15'b0_0_1_1_0_10_00010_0_1_0, // R9 frame end drained, R11 held
        15'b0_0_0_0_1_00_00010_0_0_0, // R5 empty
        15'b1_0_0_0_0_00_00010_1_0_0, // R5 one block
        15'b1_0_0_0_1_01_00000_1_0_0, // R6 cnt2 > 0
        15'b0_0_0_0_0_01_00010_0_0_0, // R6 cnt2 not > 2
        15'b0_0_1_0_0_01_00010_0_1_0, // R6/R10 cnt1
        15'b0_0_1_0_1_01_00010_0_0_0, // R11 clear, no crossing
        15'b0_0_1_0_0_00_00010_0_0_0  // R4 empty pop ignored
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1, 2:     return "R8";
            3, 4, 8:     return "R10";
            5, 9, 15:    return "R11";
            6:           return "R9";
            7:           return "R7";
            10, 11:      return "R5";
            12, 13, 14:  return "R6";
            default:     return "R4";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic pe, input logic q, input logic qe, input logic c);
        blk_push = p; eop_push = pe; blk_pop = q; eop_pop = qe; lw_irq_clr = c;
        @(negedge clk);
        blk_push = 0; eop_push = 0; blk_pop = 0; eop_pop = 0; lw_irq_clr = 0;
    endtask

    initial begin
        #200000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "q_ready", q_ready, 1'b0);
        chk("R1", "lw_irq", lw_irq, 1'b0);
        chk("R1", "push_overflow", push_overflow, 1'b0);

        for (int i = 0; i < NV; i++) begin
            rdy_rule  = VECS[i][9:8];
            lw_thresh = VECS[i][7:3];
            step(VECS[i][14], VECS[i][13], VECS[i][12], VECS[i][11], VECS[i][10]);
            chk(vec_tag(i), $sformatf("vec%0d ready", i), q_ready, VECS[i][2]);
            chk(vec_tag(i), $sformatf("vec%0d irq", i), lw_irq, VECS[i][1]);
            chk(vec_tag(i), $sformatf("vec%0d ovf", i), push_overflow, VECS[i][0]);
        end

        // R7: frame longer than capacity never becomes ready
        rdy_rule = 2'b10; lw_thresh = 5'd4;
        for (int k = 1; k <= DEPTH; k++) begin
            step(1, 0, 0, 0, 0);
            chk("R7", $sformatf("fill %0d ready", k), q_ready, 1'b0);
        end
        step(1, 0, 0, 0, 0);
        chk("R3", "ovf after full push", push_overflow, 1'b1);
        chk("R7", "stalled ready", q_ready, 1'b0);
        step(0, 0, 0, 0, 0);
        chk("R3", "ovf one cycle", push_overflow, 1'b0);
        rdy_rule = 2'b11;
        #1;
        chk("R8", "level rule at full", q_ready, 1'b1);
        // R2: push and pop together at full
        step(1, 0, 1, 0, 0);
        chk("R2", "no ovf on push+pop at full", push_overflow, 1'b0);
        step(1, 0, 0, 0, 0);
        chk("R2", "still full after push+pop", push_overflow, 1'b1);

        // R10: drain across threshold 4, irq rises exactly at 4 -> 3
        rdy_rule = 2'b01;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            step(0, 0, 1, 0, 0);
            chk("R10", $sformatf("irq at cnt %0d", k), lw_irq, (k < 4) ? 1'b1 : 1'b0);
            chk("R6", $sformatf("ready at cnt %0d", k), q_ready, (k > 4) ? 1'b1 : 1'b0);
        end
        step(0, 0, 1, 0, 0);
        chk("R4", "empty pop irq kept", lw_irq, 1'b1);
        chk("R4", "empty pop no ovf", push_overflow, 1'b0);

        // R11: crossing in clearing cycle wins
        step(0, 0, 0, 0, 1);
        chk("R11", "cleared", lw_irq, 1'b0);
        for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 1);
        chk("R11", "set beats clear", lw_irq, 1'b1);
        step(0, 0, 0, 0, 0);
        chk("R11", "stays set", lw_irq, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule